// File: doc/BRIEF.md
# SCL Low-Time Watchdog

This block guards a two-wire serial bus controller against a clock line that stays low forever. It samples the raw SCL level through a short synchroniser and measures how long the synchronised level stays low. Whenever the controller is driving the bus as master, or is waiting for the bus so it can issue a START, the block starts timing at each falling edge of SCL. If the line stays low for the programmed period, the block declares a bus error.

The limit comes from an 8-bit time-out register value supplied by the surrounding controller. Its top bit switches the function on, and its low seven bits `v` set the period to `v+1` prescaler ticks. One tick is `PRESCALE` core clock cycles. With the default divisor of 1024 on a 9 MHz clock, a tick is about 113.8 µs. Every SCL transition, and every cycle in which SCL is high, restarts both the tick counter and the prescaler, so each low phase is timed from zero.

When the time-out expires, the block raises a one-cycle error pulse for the interrupt logic. In the same cycle it issues a status-load request carrying the code 90h. It then asserts a release command so that both bus lines are let go. The block stays in this tripped state until the synchronous external reset is applied. Changes on SCL or in the configuration inputs do not clear it.

Top module: `scl_lowtime_watchdog`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `bus_err_pulse`, `stat_load` and `release_lines` are 0 and `stat_code` is 00h.
- R2: When bit 7 of `tmo_reg` is 0, no bus error is raised, however long SCL stays low.
- R3: In an armed mode, SCL is driven low and held, and `tmo_reg[6:0]` holds `v`. The first rising clock edge that samples SCL low is counted as edge 0. `bus_err_pulse` is then 1 in the cycle after edge `2+(v+1)*PRESCALE`, and it is 0 in every earlier cycle.
- R4: Any SCL transition restarts the timing. If SCL rises before expiry, no error is raised. The next low phase is then timed over the full period again.
- R5: Timing runs only while `ctrl_en` is 1 and at least one of `master_mode` or `start_wait` is 1. Otherwise no error is raised.
- R6: On expiry, `bus_err_pulse` and `stat_load` are 1 for exactly one cycle. In that cycle `stat_code` is 90h. At all other times `stat_code` is 00h.
- R7: From the expiry cycle onward, `release_lines` stays 1 and no further error pulse is raised. This holds whatever SCL, `tmo_reg` or the mode inputs do, until `rst` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high external reset |
| scl_raw | input | 1 | Asynchronous SCL level seen on the bus |
| tmo_reg | input | 8 | Time-out setting: bit 7 enable, bits 6:0 period value |
| ctrl_en | input | 1 | Controller enable |
| master_mode | input | 1 | Controller currently acts as bus master |
| start_wait | input | 1 | Controller waits for the bus to issue a START |
| bus_err_pulse | output | 1 | One-cycle bus-error interrupt request |
| stat_load | output | 1 | Request to load the status register |
| stat_code | output | 8 | Status code to load (90h with `stat_load`) |
| release_lines | output | 1 | Command to release SCL and SDA |

## Verification
On every cycle, the assertions check the following. An error pulse lasts a single cycle and arrives together with the status request and the 90h code. An error only appears when the previous cycle had the enable bit, the controller enable and an armed mode set. Once the release command is asserted, it never drops until reset. The exact expiry latency in clock cycles, the restart of timing on an SCL rise, and the fact that nothing fires in slave or disabled configurations all depend on held stimulus. Only the bench's directed scenarios can show these, by counting cycles from the SCL fall.

// File: rtl/wd_pkg.sv
package wd_pkg;

    localparam int TMO_W = 8;
    localparam logic [7:0] BUS_ERR_CODE = 8'h90;

    typedef struct packed {
        logic              en;
        logic [TMO_W-2:0]  val;
    } tmo_cfg_t;

    typedef enum logic {
        WD_RUN  = 1'b0,
        WD_TRIP = 1'b1
    } wd_state_t;

    function automatic tmo_cfg_t decode_tmo(input logic [TMO_W-1:0] raw);
        tmo_cfg_t c;
        c.en  = raw[TMO_W-1];
        c.val = raw[TMO_W-2:0];
        return c;
    endfunction

endpackage

// File: rtl/wd_sync.sv
module wd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic edge_seen
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b1;
        else     last_q <= chain[STAGES-1];
    end

    assign level     = chain[STAGES-1];
    assign edge_seen = chain[STAGES-1] ^ last_q;
endmodule

// File: rtl/wd_prescaler.sv
module wd_prescaler #(
    parameter int PRESCALE = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] div_q;

    assign tick = !clr && (div_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr)  div_q <= '0;
        else if (tick)   div_q <= '0;
        else             div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/wd_lowcount.sv
module wd_lowcount #(
    parameter int VW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reload,
    input  logic          tick,
    input  logic [VW-1:0] load_val,
    output logic          expire
);
    logic [VW-1:0] left_q;

    assign expire = !reload && tick && (left_q == '0);

    always_ff @(posedge clk) begin
        if (rst || reload)  left_q <= load_val;
        else if (tick && left_q != '0) left_q <= left_q - 1'b1;
    end
endmodule

// File: rtl/scl_lowtime_watchdog.sv
module scl_lowtime_watchdog
    import wd_pkg::*;
#(
    parameter int PRESCALE    = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_raw,
    input  logic [TMO_W-1:0] tmo_reg,
    input  logic             ctrl_en,
    input  logic             master_mode,
    input  logic             start_wait,
    output logic             bus_err_pulse,
    output logic             stat_load,
    output logic [7:0]       stat_code,
    output logic             release_lines
);
    localparam int VW = TMO_W - 1;

    tmo_cfg_t  cfg;
    wd_state_t state_q;
    logic      scl_lvl, scl_edge;
    logic      armed, reload, tick, expire;
    logic      err_q;

    assign cfg = decode_tmo(tmo_reg);

    wd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .din       (scl_raw),
        .level     (scl_lvl),
        .edge_seen (scl_edge)
    );

    assign armed  = ctrl_en && cfg.en && (master_mode || start_wait)
                    && (state_q == WD_RUN);
    assign reload = !armed || scl_lvl || scl_edge;

    wd_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  (reload),
        .tick (tick)
    );

    wd_lowcount #(.VW(VW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .reload   (reload),
        .tick     (tick),
        .load_val (cfg.val),
        .expire   (expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WD_RUN;
            err_q   <= 1'b0;
        end else begin
            err_q <= 1'b0;
            if (expire) begin
                state_q <= WD_TRIP;
                err_q   <= 1'b1;
            end
        end
    end

    assign bus_err_pulse = err_q;
    assign stat_load     = err_q;
    assign stat_code     = err_q ? BUS_ERR_CODE : 8'h00;
    assign release_lines = (state_q == WD_TRIP);
endmodule

// File: rtl/wd_checker.sv
module wd_checker (
    input logic       clk,
    input logic       rst,
    input logic [7:0] tmo_reg,
    input logic       ctrl_en,
    input logic       master_mode,
    input logic       start_wait,
    input logic       bus_err_pulse,
    input logic       stat_load,
    input logic [7:0] stat_code,
    input logic       release_lines
);
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        bus_err_pulse |=> !bus_err_pulse); // R6

    AST_STATUS_WITH_ERR: assert property (@(posedge clk) disable iff (rst)
        bus_err_pulse |-> (stat_load && stat_code == 8'h90)); // R6

    AST_CODE_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !stat_load |-> (stat_code == 8'h00)); // R6

    AST_ERR_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        bus_err_pulse |-> $past(tmo_reg[7] && ctrl_en)); // R2

    AST_ERR_NEEDS_MODE: assert property (@(posedge clk) disable iff (rst)
        bus_err_pulse |-> $past(master_mode || start_wait)); // R5

    AST_RELEASE_STICKY: assert property (@(posedge clk) disable iff (rst)
        release_lines |=> release_lines); // R7

    AST_RELEASE_ON_ERR: assert property (@(posedge clk) disable iff (rst)
        bus_err_pulse |-> release_lines); // R7

    AST_NO_REPEAT_ERR: assert property (@(posedge clk) disable iff (rst)
        release_lines |=> !bus_err_pulse); // R7
endmodule

bind scl_lowtime_watchdog wd_checker u_wd_checker (
    .clk           (clk),
    .rst           (rst),
    .tmo_reg       (tmo_reg),
    .ctrl_en       (ctrl_en),
    .master_mode   (master_mode),
    .start_wait    (start_wait),
    .bus_err_pulse (bus_err_pulse),
    .stat_load     (stat_load),
    .stat_code     (stat_code),
    .release_lines (release_lines)
);

// File: tb/tb_scl_lowtime_watchdog.sv
module tb_scl_lowtime_watchdog;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_raw = 1'b1;
    logic [7:0] tmo_reg = 8'hFF;
    logic       ctrl_en = 1'b0;
    logic       master_mode = 1'b0;
    logic       start_wait = 1'b0;
    logic       bus_err_pulse, stat_load, release_lines;
    logic [7:0] stat_code;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scl_lowtime_watchdog #(.PRESCALE(DIV)) dut (
        .clk           (clk),
        .rst           (rst),
        .scl_raw       (scl_raw),
        .tmo_reg       (tmo_reg),
        .ctrl_en       (ctrl_en),
        .master_mode   (master_mode),
        .start_wait    (start_wait),
        .bus_err_pulse (bus_err_pulse),
        .stat_load     (stat_load),
        .stat_code     (stat_code),
        .release_lines (release_lines)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; scl_raw = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Drop SCL at a negedge and count negedge samples until the error pulse.
    task automatic measure(input int limit, output int lat);
        lat = -1;
        scl_raw = 1'b0;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (bus_err_pulse) begin
                lat = i;
                break;
            end
        end
    endtask

    function automatic int expect_lat(input int v);
        return 3 + (v + 1) * DIV;
    endfunction

    task automatic t_reset_state();
        @(negedge clk);
        check("R1 err in reset", bus_err_pulse, 0);
        check("R1 release in reset", release_lines, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 stat_load after reset", stat_load, 0);
        check("R1 code after reset", stat_code, 0);
    endtask

    task automatic t_master_expiry(input int v);
        int lat;
        do_reset();
        ctrl_en = 1; master_mode = 1; start_wait = 0;
        tmo_reg = 8'h80 | v[7:0];
        @(negedge clk);
        measure(expect_lat(v) + 20, lat);
        check("R3 expiry latency", lat, expect_lat(v));
        check("R6 stat_load with err", stat_load, 1);
        check("R6 code 90h", stat_code, 8'h90);
        check("R7 release at err", release_lines, 1);
        @(negedge clk);
        check("R6 pulse one cycle", bus_err_pulse, 0);
        check("R6 code back to 0", stat_code, 0);
    endtask

    task automatic t_sticky();
        int seen = 0;
        // continues from a tripped state
        scl_raw = 1'b1; tmo_reg = 8'h00; master_mode = 0; ctrl_en = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (i == 10) begin scl_raw = 1'b0; ctrl_en = 1; master_mode = 1; tmo_reg = 8'h80; end
            if (bus_err_pulse) seen++;
        end
        check("R7 release held", release_lines, 1);
        check("R7 no repeat error", seen, 0);
        do_reset();
        check("R7 reset clears release", release_lines, 0);
    endtask

    task automatic t_restart();
        int lat;
        int seen = 0;
        do_reset();
        ctrl_en = 1; master_mode = 1; tmo_reg = 8'h83;
        @(negedge clk);
        scl_raw = 1'b0;
        for (int i = 0; i < 25; i++) begin
            @(negedge clk);
            if (bus_err_pulse) seen++;
        end
        scl_raw = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (bus_err_pulse) seen++;
        end
        check("R4 no error before rise", seen, 0);
        measure(expect_lat(3) + 20, lat);
        check("R4 full period after restart", lat, expect_lat(3));
    endtask

    task automatic t_no_fire(input string req, input logic en_b, input logic ce,
                             input logic mm, input logic sw);
        int seen = 0;
        do_reset();
        ctrl_en = ce; master_mode = mm; start_wait = sw;
        tmo_reg = {en_b, 7'h01};
        @(negedge clk);
        scl_raw = 1'b0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (bus_err_pulse || release_lines) seen++;
        end
        check(req, seen, 0);
    endtask

    task automatic t_start_wait();
        int lat;
        do_reset();
        ctrl_en = 1; master_mode = 0; start_wait = 1; tmo_reg = 8'h82;
        @(negedge clk);
        measure(expect_lat(2) + 20, lat);
        check("R5 start-wait expiry", lat, expect_lat(2));
        start_wait = 0;
    endtask

    initial begin
        t_reset_state();
        t_master_expiry(3);
        t_sticky();
        t_master_expiry(0);
        t_restart();
        t_no_fire("R2 enable bit clear", 1'b0, 1'b1, 1'b1, 1'b0);
        t_no_fire("R5 controller disabled", 1'b1, 1'b0, 1'b1, 1'b0);
        t_no_fire("R5 slave mode", 1'b1, 1'b1, 1'b0, 1'b0);
        t_start_wait();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                bad++;
                total++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule